// File: doc/BRIEF.md
# Single-Slope Integrating ADC Conversion Controller

This block is the digital half of a single-slope integrating analog-to-digital converter. An external integrator ramps up from zero while a comparator reports whether the held input still lies above the ramp. The controller waits in standby with the track-and-hold tracking and the integrator clamped. A rising edge on the convert command clears the counter, switches the track-and-hold to hold and unclamps the integrator.

During the conversion the counter advances once per clock for as long as the synchronized comparator stays high. When the comparator falls, the controller stops counting and latches the count as the result. It pulses end-of-conversion, clamps the integrator again, returns the track-and-hold to tracking and goes back to standby. The conversion length therefore follows the input amplitude: larger inputs take longer. A full-scale 10-bit conversion lasts about 1023 clocks. If the counter reaches all ones while the comparator is still high, the conversion ends at once and an over-range flag is set.

Top module: `ssadc_ctrl`

## Requirements
- R1: While reset is asserted and right after it, hold_o is 0, ramp_rst_o is 1, and count_o, eoc_o and ovr_o are all 0.
- R2: A rising edge of conv_i sampled in standby at clock edge 0 gives hold_o = 1 and ramp_rst_o = 0 from that edge on.
- R3: cmp_i passes through a two-stage synchronizer. If cmp_i falls between edges D and D+1 after the start edge, eoc_o rises at edge D+3 with count_o = D+2, provided D+2 does not exceed 2^CNT_W-1.
- R4: If the synchronized comparator is already low when the conversion starts, the conversion ends at edge 1 with count_o = 0.
- R5: In the cycle eoc_o is high, hold_o is 0 and ramp_rst_o is 1, and the block stays in standby until a new convert edge.
- R6: eoc_o is high for exactly one cycle per conversion, together with the new count_o and ovr_o.
- R7: If the count reaches 2^CNT_W-1 while the comparator is still high, the conversion ends at edge 2^CNT_W with count_o all ones and ovr_o = 1. A result of exactly 2^CNT_W-1 reached through a comparator fall gives ovr_o = 0.
- R8: A rising edge of conv_i while a conversion is running is ignored: it changes neither the end time nor the result.
- R9: count_o and ovr_o keep their values until the next conversion completes.
- R10: Holding conv_i high after a conversion ends does not start another conversion; only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert command, acted on at its rising edge |
| cmp_i | input | 1 | Comparator result, high while the held input exceeds the ramp; asynchronous |
| hold_o | output | 1 | Track-and-hold control, 1 = hold, 0 = track |
| ramp_rst_o | output | 1 | Integrator clamp, 1 = ramp held at zero |
| count_o | output | CNT_W | Result of the last completed conversion |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| ovr_o | output | 1 | Last conversion saturated at full scale |

## Verification
The assertions assume that conv_i is synchronous to clk and that the bench holds rst_n low from time zero. Any cmp_i timing is allowed, because cmp_i passes through the synchronizer before any property can observe it. The stimulus changes conv_i and cmp_i only at falling clock edges. Before a conversion starts it leaves cmp_i steady for several cycles so that the synchronizer has settled. A mid-conversion convert pulse is only sent when the conversion will still be running at that point, so the test really exercises the ignore path.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    typedef enum logic [0:0] {
        ST_STANDBY = 1'b0,
        ST_RAMP    = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ssadc_sync.sv
module ssadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_o = r_q.chain[STAGES-1];

endmodule

// File: rtl/ssadc_edge.sv
module ssadc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rise_o = level_i & ~r_q.prev;

endmodule

// File: rtl/ssadc_count.sv
module ssadc_count #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);

    localparam logic [CNT_W-1:0] FULL_VAL = '1;
    localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (inc_i && (r_q.cnt != FULL_VAL)) begin
            r_d.cnt = r_q.cnt + ONE_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign full_o = (r_q.cnt == FULL_VAL);

endmodule

// File: rtl/ssadc_seq.sv
module ssadc_seq
    import ssadc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             above_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             full_i,
    output logic             clr_o,
    output logic             inc_o,
    output logic             hold_o,
    output logic             ramp_rst_o,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o,
    output logic             ovr_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] result;
        logic             done;
        logic             ovr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic running;
    logic end_fall;
    logic end_full;

    always_comb begin
        running  = (r_q.state == ST_RAMP);
        end_fall = running && !above_i;
        end_full = running && above_i && full_i;

        clr_o = (r_q.state == ST_STANDBY) && start_i;
        inc_o = running && above_i && !full_i;

        r_d      = r_q;
        r_d.done = 1'b0;

        case (r_q.state)
            ST_STANDBY: begin
                if (start_i) begin
                    r_d.state = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (end_fall || end_full) begin
                    r_d.state  = ST_STANDBY;
                    r_d.result = cnt_i;
                    r_d.done   = 1'b1;
                    r_d.ovr    = end_full;
                end
            end
            default: begin
                r_d.state = ST_STANDBY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_STANDBY, result: '0, done: 1'b0, ovr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_o     = (r_q.state == ST_RAMP);
    assign ramp_rst_o = (r_q.state != ST_RAMP);
    assign result_o   = r_q.result;
    assign done_o     = r_q.done;
    assign ovr_o      = r_q.ovr;

endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic             cmp_i,
    output logic             hold_o,
    output logic             ramp_rst_o,
    output logic [CNT_W-1:0] count_o,
    output logic             eoc_o,
    output logic             ovr_o
);

    logic             cmp_sync;
    logic             conv_rise;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             cnt_full;
    logic [CNT_W-1:0] cnt_val;

    ssadc_sync #(
        .STAGES (SYNC_STAGES)
    ) i_cmp_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_sync)
    );

    ssadc_edge i_conv_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (conv_i),
        .rise_o  (conv_rise)
    );

    ssadc_count #(
        .CNT_W (CNT_W)
    ) i_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt_val),
        .full_o (cnt_full)
    );

    ssadc_seq #(
        .CNT_W (CNT_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (conv_rise),
        .above_i    (cmp_sync),
        .cnt_i      (cnt_val),
        .full_i     (cnt_full),
        .clr_o      (cnt_clr),
        .inc_o      (cnt_inc),
        .hold_o     (hold_o),
        .ramp_rst_o (ramp_rst_o),
        .result_o   (count_o),
        .done_o     (eoc_o),
        .ovr_o      (ovr_o)
    );

endmodule

// File: rtl/ssadc_chk.sv
module ssadc_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_i,
    input logic             hold_o,
    input logic             ramp_rst_o,
    input logic [CNT_W-1:0] count_o,
    input logic             eoc_o,
    input logic             ovr_o
);

    AST_START_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(conv_i)); // R2

    AST_EOC_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> (!hold_o && ramp_rst_o)); // R5

    AST_EOC_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> $past(hold_o)); // R3

    AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> !eoc_o); // R6

    AST_OVR_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && ovr_o) |-> (&count_o)); // R7

    AST_COUNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> $stable(count_o)); // R9

    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> $stable(ovr_o)); // R9

endmodule

bind ssadc_ctrl ssadc_chk #(
    .CNT_W (CNT_W)
) i_ssadc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_i     (conv_i),
    .hold_o     (hold_o),
    .ramp_rst_o (ramp_rst_o),
    .count_o    (count_o),
    .eoc_o      (eoc_o),
    .ovr_o      (ovr_o)
);

// File: tb/test_ssadc_ctrl.sv
module test_ssadc_ctrl;

    localparam int CNT_W    = 10;
    localparam int FULL     = (1 << CNT_W) - 1;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_i = 1'b0;
    logic             cmp_i = 1'b1;
    logic             hold_o;
    logic             ramp_rst_o;
    logic [CNT_W-1:0] count_o;
    logic             eoc_o;
    logic             ovr_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ssadc_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_ssadc_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv_i),
        .cmp_i      (cmp_i),
        .hold_o     (hold_o),
        .ramp_rst_o (ramp_rst_o),
        .count_o    (count_o),
        .eoc_o      (eoc_o),
        .ovr_o      (ovr_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result from R3/R4/R7
    function automatic int exp_count(input int d, input bit low_start);
        if (low_start) return 0;
        if (d + 2 > FULL) return FULL;
        return d + 2;
    endfunction

    function automatic int exp_end(input int d, input bit low_start);
        if (low_start) return 1;
        if (d + 2 > FULL) return FULL + 1;
        return d + 3;
    endfunction

    function automatic int exp_ovr(input int d, input bit low_start);
        return (!low_start && (d + 2 > FULL)) ? 1 : 0;
    endfunction

    // d: cmp_i falls between edges d and d+1 after the start edge
    task automatic do_conv(input int d, input bit low_start, input bit poke, input bit keep_high);
        int prev_cnt;
        int prev_ovr;
        int j;
        @(negedge clk);
        cmp_i  = !low_start;
        conv_i = 1'b0;
        repeat (4) @(negedge clk);
        prev_cnt = int'(count_o);
        prev_ovr = int'(ovr_o);
        conv_i = 1'b1;
        j = -1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            j++;
            if (j == 0) begin
                check("R2 hold", int'(hold_o), 1);
                check("R2 ramp_rst", int'(ramp_rst_o), 0);
            end
            if (j == 1 && !keep_high) conv_i = 1'b0;
            if (poke && j == 4) conv_i = 1'b1;  // R8 busy convert edge
            if (poke && j == 6) conv_i = 1'b0;
            if (!low_start && j == d) cmp_i = 1'b0;
            if (eoc_o) break;
            if (j == 2) begin
                check("R9 count kept", int'(count_o), prev_cnt);
                check("R9 ovr kept", int'(ovr_o), prev_ovr);
            end
            if (j > FULL + 10) begin
                check("R3 no end", j, exp_end(d, low_start));
                break;
            end
        end
        check(low_start ? "R4 end edge" : (poke ? "R8 end edge" : "R3 end edge"), j, exp_end(d, low_start));
        check(low_start ? "R4 count" : "R3/R7 count", int'(count_o), exp_count(d, low_start));
        check("R7 ovr", int'(ovr_o), exp_ovr(d, low_start));
        check("R5 hold", int'(hold_o), 0);
        check("R5 ramp_rst", int'(ramp_rst_o), 1);
        @(negedge clk);
        check("R6 eoc pulse", int'(eoc_o), 0);
        cmp_i = 1'b1;
        if (keep_high) begin
            repeat (6) @(negedge clk);
            check("R10 no restart", int'(hold_o), 0);
            check("R10 count kept", int'(count_o), exp_count(d, low_start));
            conv_i = 1'b0;
        end
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 hold", int'(hold_o), 0);
        check("R1 ramp_rst", int'(ramp_rst_o), 1);
        check("R1 eoc", int'(eoc_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", int'(count_o), 0);
        check("R1 ovr", int'(ovr_o), 0);

        do_conv(5, 1'b0, 1'b0, 1'b0);
        do_conv(0, 1'b1, 1'b0, 1'b0);          // R4
        do_conv(0, 1'b0, 1'b0, 1'b0);
        do_conv(FULL - 2, 1'b0, 1'b0, 1'b0);   // R7 exact full, no over-range
        do_conv(FULL + 40, 1'b0, 1'b0, 1'b0);  // R7 saturation
        do_conv(FULL - 1, 1'b0, 1'b0, 1'b0);   // R7 boundary
        do_conv(30, 1'b0, 1'b1, 1'b0);         // R8
        do_conv(12, 1'b0, 1'b0, 1'b1);         // R10

        for (int k = 0; k < 24; k++) begin
            int d;
            int sel;
            sel = int'($urandom_range(0, 9));
            d   = (sel == 0) ? int'($urandom_range(FULL - 3, FULL + 3))
                             : int'($urandom_range(0, 400));
            do_conv(d, (sel == 1), (d > 10) && (sel > 6), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule